// File: doc/BRIEF.md
# Run-Length Sample Packer

The packer takes a stream of 16-bit logic samples, one per accepted handshake, and folds consecutive equal samples into run-length packets. Each packet carries the sample value and an 8-bit repeat count. Five packets plus a trailing sequence byte make one fixed 16-byte transfer unit, and these units leave the block as a byte stream.

A flush request closes the current run. It then pads any partly filled unit with zero-value, zero-count packets, so the host always receives whole units. Two counters report how many data packets have been produced since reset, and how many of them were produced before the first trigger pulse. A pre-trigger count of zero therefore places the trigger at the very start of the record.

Both streams use valid/ready. A byte is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered byte and its `out_last` flag hold. The block holds one finished packet inside. While that packet waits for the output, and for the whole of a flush, `in_ready` is low, so no sample is lost. A sample is taken on an edge where `in_valid` and `in_ready` are both high.

Top module: `rle_packer`

## Requirements
- R1: During and directly after reset, `out_valid` and `out_last` are 0, `in_ready` is 1, and both packet counters read 0.
- R2: Each packet is three bytes in this order: sample value bits 7:0, then sample value bits 15:8, then the repeat count. Bytes 0 to 14 of a unit are five packets, and byte 15 is the sequence byte.
- R3: The repeat count equals the number of consecutive accepted samples of that value. A run closes when a sample with a different value arrives, or when a further equal sample arrives while the count is already 255.
- R4: The sequence byte of the first unit after reset is 0. It rises by one per unit and wraps from 255 to 0.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle. Every accepted sample appears in the output counts.
- R6: A flush pulse emits the open run and pads the unit with packets whose value and count are 0, until byte 15 is reached. `out_last` is 1 on exactly that sequence byte. `in_ready` is 0 in the cycle after the pulse.
- R7: A flush with no open run at a unit boundary, after all bytes have gone out, adds no bytes and leaves the counters unchanged.
- R8: `pkt_total` counts data packets produced since reset. Padding packets are not counted.
- R9: `pkt_pre_trig` counts the data packets produced in cycles before the first `trig` pulse since reset. It stops counting from the cycle of that pulse, so a pulse before any packet leaves it at 0. Later pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_sample | input | 16 | Sample value |
| flush | input | 1 | Pulse: close the run and complete the unit |
| trig | input | 1 | Pulse: trigger position marker |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a flushed record |
| pkt_total | output | 32 | Data packets produced since reset |
| pkt_pre_trig | output | 32 | Data packets produced before the first trigger |

## Verification
A wrong run counter or run-close decision shows up in the third byte of the affected packet. That byte appears only after the next value change or flush, so the sweep over run lengths 1 to 300 aims at the boundaries at 255 and 256. A slipped byte or slot index misplaces the sequence byte within the same unit, and the checker's own byte position catches it at once. A sequence counter that skips or wraps early is caught at the next sequence byte, including across the 255-to-0 wrap. Trigger counting errors remain hidden in the registers, so they are read at the ports before and after further pulses.

// File: rtl/rle_pkg.sv
package rle_pkg;
  parameter int SAMPLE_W = 16;
  parameter int RUN_W    = 8;

  typedef struct packed {
    logic [SAMPLE_W-1:0] val;
    logic [RUN_W-1:0]    cnt;
  } pkt_t;
endpackage

// File: rtl/rle_run_acc.sv
module rle_run_acc
  import rle_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                in_ready,
  input  logic                flush_req,
  input  logic                unit_idle,
  input  logic                pop,
  output logic                pkt_valid,
  output pkt_t                pkt,
  output logic                push,
  output logic                run_open,
  output logic                flush_busy
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  pkt_t cur;
  logic acc, close_smp, close_fl;

  assign in_ready  = !flush_busy && !pkt_valid;
  assign acc       = in_valid && in_ready;
  assign close_smp = acc && run_open && ((in_sample != cur.val) || (cur.cnt == RUN_MAX));
  assign close_fl  = flush_busy && run_open && !pkt_valid;
  assign push      = close_smp || close_fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= '0;
      run_open   <= 1'b0;
      pkt        <= '0;
      pkt_valid  <= 1'b0;
      flush_busy <= 1'b0;
    end else begin
      // holding register: one closed packet waiting for the serializer
      if (push) begin
        pkt       <= cur;
        pkt_valid <= 1'b1;
      end else if (pop) begin
        pkt_valid <= 1'b0;
      end
      // open run
      if (acc) begin
        if (!run_open || close_smp) begin
          cur.val  <= in_sample;
          cur.cnt  <= RUN_ONE;
          run_open <= 1'b1;
        end else begin
          cur.cnt <= cur.cnt + RUN_ONE;
        end
      end else if (close_fl) begin
        run_open <= 1'b0;
      end
      // flush sequencing ends once everything has left at a unit boundary
      if (flush_req)
        flush_busy <= 1'b1;
      else if (flush_busy && !run_open && !pkt_valid && unit_idle)
        flush_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_unit_ser.sv
module rle_unit_ser
  import rle_pkg::*;
#(
  parameter int PKTS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_valid,
  input  pkt_t       pkt,
  input  logic       flush_busy,
  input  logic       run_open,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       pop,
  output logic       unit_idle
);
  localparam int VAL_BYTES = SAMPLE_W / 8;
  localparam int PKT_BYTES = VAL_BYTES + 1;
  localparam int BSEL_W    = $clog2(PKT_BYTES);
  localparam int SLOT_W    = $clog2(PKTS + 1);
  localparam logic [BSEL_W-1:0] BSEL_LAST = BSEL_W'(PKT_BYTES - 1);
  localparam logic [SLOT_W-1:0] SEQ_SLOT  = SLOT_W'(PKTS);

  logic [SLOT_W-1:0] slot;
  logic [BSEL_W-1:0] bsel;
  logic [7:0]        seq;
  logic [7:0]        pkt_byte;
  logic              seq_phase, drained, pad, fire;

  assign seq_phase = (slot == SEQ_SLOT);
  assign drained   = flush_busy && !run_open && !pkt_valid;
  assign pad       = drained && (slot != '0) && !seq_phase;
  assign out_valid = seq_phase || pkt_valid || pad;
  assign out_last  = seq_phase && drained;
  assign fire      = out_valid && out_ready;
  assign pop       = fire && !seq_phase && !pad && (bsel == BSEL_LAST);
  assign unit_idle = (slot == '0) && (bsel == '0);

  always_comb begin
    pkt_byte = pkt.cnt;
    for (int i = 0; i < VAL_BYTES; i++)
      if (bsel == BSEL_W'(i)) pkt_byte = pkt.val[i*8 +: 8];
  end

  assign out_data = seq_phase ? seq : (pad ? 8'h00 : pkt_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      bsel <= '0;
      seq  <= '0;
    end else if (fire) begin
      if (seq_phase) begin
        slot <= '0;
        seq  <= seq + 8'd1;
      end else if (bsel == BSEL_LAST) begin
        bsel <= '0;
        slot <= slot + SLOT_W'(1);
      end else begin
        bsel <= bsel + BSEL_W'(1);
      end
    end
  end
endmodule

// File: rtl/rle_pkt_counters.sv
module rle_pkt_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             trig,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] pre
);
  logic trig_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total     <= '0;
      pre       <= '0;
      trig_seen <= 1'b0;
    end else begin
      if (push) total <= total + CNT_W'(1);
      if (push && !trig_seen && !trig) pre <= pre + CNT_W'(1);
      if (trig) trig_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/rle_packer.sv
module rle_packer
  import rle_pkg::*;
#(
  parameter int PKTS_PER_UNIT = 5,
  parameter int CNT_REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  in_sample,
  input  logic                 flush,
  input  logic                 trig,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_last,
  output logic [CNT_REG_W-1:0] pkt_total,
  output logic [CNT_REG_W-1:0] pkt_pre_trig
);
  pkt_t pkt;
  logic pkt_valid, push, pop, run_open, flush_busy, unit_idle;

  rle_run_acc u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .flush_req(flush), .unit_idle(unit_idle), .pop(pop),
    .pkt_valid(pkt_valid), .pkt(pkt), .push(push), .run_open(run_open),
    .flush_busy(flush_busy)
  );

  rle_unit_ser #(.PKTS(PKTS_PER_UNIT)) u_ser (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt(pkt),
    .flush_busy(flush_busy), .run_open(run_open), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .pop(pop), .unit_idle(unit_idle)
  );

  rle_pkt_counters #(.CNT_W(CNT_REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .push(push), .trig(trig),
    .total(pkt_total), .pre(pkt_pre_trig)
  );
endmodule

// File: rtl/rle_packer_chk.sv
module rle_packer_chk #(
  parameter int PKTS  = 5,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic [CNT_W-1:0] pkt_total,
  input logic [CNT_W-1:0] pkt_pre_trig
);
  localparam int UNIT_BYTES = PKTS * 3 + 1;
  localparam int POS_W      = $clog2(UNIT_BYTES + 1);
  localparam logic [POS_W-1:0] POS_SEQ = POS_W'(UNIT_BYTES - 1);

  logic [POS_W-1:0] pos;
  logic [7:0]       units;
  logic             fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      units <= '0;
    end else if (fire) begin
      if (pos == POS_SEQ) begin
        pos   <= '0;
        units <= units + 8'd1;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  a_r4_seq_value: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pos == POS_SEQ) |-> (out_data == units));

  a_r6_last_at_unit_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (pos == POS_SEQ));

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r6_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !in_ready);

  a_r9_pre_not_above_total: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_pre_trig <= pkt_total);

  a_r8_total_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pkt_total - $past(pkt_total)) <= CNT_W'(1)));
endmodule

bind rle_packer rle_packer_chk #(.PKTS(PKTS_PER_UNIT), .CNT_W(CNT_REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .flush(flush),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .pkt_total(pkt_total), .pkt_pre_trig(pkt_pre_trig)
);

// File: tb/sim_rle_packer.sv
module sim_rle_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        flush = 1'b0;
  logic        trig = 1'b0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_data;
  logic [31:0] pkt_total, pkt_pre_trig;

  always #5 clk = ~clk;

  rle_packer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .flush(flush), .trig(trig), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .pkt_total(pkt_total), .pkt_pre_trig(pkt_pre_trig)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic       exp_l[$];
  logic [7:0] got_q[$];
  logic       got_l[$];

  bit          m_open;
  logic [15:0] m_val;
  int          m_cnt, m_slot, m_total, m_pre;
  logic [7:0]  m_seq;
  bit          m_trig;
  bit          bp_rand = 1'b0;
  bit          prev_stall = 1'b0;
  logic [7:0]  prev_data;
  logic        prev_last;
  bit          done = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference model
  function automatic void m_push(logic [15:0] v, int c, bit data);
    exp_q.push_back(v[7:0]);  exp_l.push_back(1'b0);
    exp_q.push_back(v[15:8]); exp_l.push_back(1'b0);
    exp_q.push_back(8'(c));   exp_l.push_back(1'b0);
    if (data) m_total++;
    m_slot++;
    if (m_slot == 5) begin
      exp_q.push_back(m_seq); exp_l.push_back(1'b0);
      m_seq = m_seq + 8'd1;
      m_slot = 0;
    end
  endfunction

  function automatic void m_sample(logic [15:0] v);
    if (!m_open) begin
      m_open = 1; m_val = v; m_cnt = 1;
    end else if (v != m_val || m_cnt == 255) begin
      m_push(m_val, m_cnt, 1'b1);
      m_val = v; m_cnt = 1;
    end else begin
      m_cnt++;
    end
  endfunction

  function automatic void m_flush();
    bit had = 0;
    if (m_open) begin m_push(m_val, m_cnt, 1'b1); m_open = 0; had = 1; end
    while (m_slot != 0) begin m_push(16'h0, 0, 1'b0); had = 1; end
    if (had) exp_l[exp_l.size()-1] = 1'b1;
  endfunction

  // output collector and stall-hold check
  initial begin
    forever begin
      @(negedge clk);
      if (done) break;
      out_ready = bp_rand ? 1'($urandom_range(0, 1)) : 1'b1;
      if (rst_n && prev_stall)
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R5", "stalled byte changed", {out_valid, out_data}, {1'b1, prev_data});
      if (rst_n && out_valid && out_ready) begin
        got_q.push_back(out_data);
        got_l.push_back(out_last);
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0; trig = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_last, "R1", "outputs in reset", {out_valid, out_last}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_open = 0; m_slot = 0; m_total = 0; m_pre = 0; m_seq = 8'h00; m_trig = 0;
    got_q.delete(); got_l.delete(); exp_q.delete(); exp_l.delete();
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(pkt_total == 0, "R1", "pkt_total after reset", pkt_total, 0);
    check(pkt_pre_trig == 0, "R1", "pkt_pre_trig after reset", pkt_pre_trig, 0);
  endtask

  task automatic send(logic [15:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_sample = v;
    while (!in_ready) @(negedge clk);
    m_sample(v);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    in_valid = 1'b0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (!m_trig) begin m_trig = 1; m_pre = m_total; end
  endtask

  task automatic do_flush();
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(in_ready == 1'b0, "R6", "in_ready during flush", in_ready, 0);
    m_flush();
    for (int i = 0; i < 30000 && got_q.size() < exp_q.size(); i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic compare(string tag);
    int n;
    check(got_q.size() == exp_q.size(), "R2", {tag, " byte count"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      int p;
      string r;
      p = i % 16;
      r = (p == 15) ? "R4" : ((p % 3 == 2) ? "R3" : "R2");
      check(got_q[i] == exp_q[i], r, {tag, " byte"}, got_q[i], exp_q[i]);
      check(got_l[i] == exp_l[i], "R6", {tag, " last flag"}, got_l[i], exp_l[i]);
    end
    check(pkt_total == 32'(m_total), "R8", {tag, " pkt_total"}, pkt_total, m_total);
    check(pkt_pre_trig == 32'(m_trig ? m_pre : m_total), "R9", {tag, " pkt_pre_trig"},
          pkt_pre_trig, m_trig ? m_pre : m_total);
    got_q.delete(); got_l.delete(); exp_q.delete(); exp_l.delete();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset; R9 trigger before any packet
    do_reset();
    pulse_trig();
    for (int l = 1; l <= 40; l++)
      for (int k = 0; k < l; k++) send(16'(l * 37 + 1));
    do_flush();
    compare("short runs, trig at start");
    check(pkt_pre_trig == 0, "R9", "trigger at start", pkt_pre_trig, 0);

    // R3 sweep across the 255 boundary under random back-pressure, trigger midway
    do_reset();
    bp_rand = 1'b1;
    for (int l = 1; l <= 300; l++) begin
      for (int k = 0; k < l; k++) send(16'(l * 37 + 1));
      if (l == 150) pulse_trig();
      if (l == 220) pulse_trig();
    end
    do_flush();
    compare("length sweep");

    // R7 flush with nothing open at a unit boundary
    do_flush();
    compare("empty flush");
    check(m_total == pkt_total, "R7", "counters unchanged", pkt_total, m_total);

    // R6 flush where the open run completes a unit exactly
    do_reset();
    bp_rand = 1'b0;
    for (int i = 0; i < 5; i++) send(16'(16'h1000 + i));
    do_flush();
    compare("exact unit");

    // R4 sequence wrap with single-sample runs, random back-pressure
    do_reset();
    bp_rand = 1'b1;
    for (int i = 0; i < 1303; i++) send(i[0] ? 16'hA5A5 : 16'h5A5A);
    do_flush();
    compare("sequence wrap");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule